// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Binary Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. It divides each operand into an upper and a lower half and forms four half-width products. It then merges them with ripple-carry adders. The two cross products are summed first. That sum is shifted by half the width, and the upper-by-upper product is shifted by the full width. Each half-width product is built the same way, so the recursion bottoms out in a 2x2 cell. That cell forms its bits column by column: the straight products down each column and the crosswise products for the middle column.

The width N is a parameter and may be 2, 4 or 8; it must be a power of two. A parameter also selects between two output forms. In one, the product is captured in an output register with a synchronous, active-high reset. In the other, the product leaves the adder tree directly, with no register. The registered form suits timing closure, because it places a register boundary at the end of the long carry path.

Top module: `vcm_mult`

## Requirements
- R1: For every pair of unsigned operands, the result equals a*b written as an unsigned 2N-bit value, with no bits dropped; at N=4 this holds for all 256 pairs.
- R2: Each level forms its product as (upper·upper) shifted left by N, plus (upper·lower + lower·upper) shifted left by N/2, plus (lower·lower) unshifted, where the upper half is bits [N-1:N/2] and the lower half is bits [N/2-1:0].
- R3: The 2x2 cell gives bit 0 = a[0]&b[0] and bit 1 = (a[1]&b[0]) ^ (a[0]&b[1]); the carry of that column flows into bits 2 and 3. Bit 3 is set only for 3×3 = 9.
- R4: The carry out of the adder that adds in the upper·upper product is always zero, because the product fits in 2N bits.
- R5: The carry out of the cross-product adder is kept. It can never coincide with the carry out of the adder that merges the cross sum with the upper half of lower·lower. With all-ones operands at N=8, the result is 16'hFE01.
- R6: With REG_OUT=1, the output shows the product of the operands sampled at a rising clock edge, from that edge on. While reset is high at an edge, the output is cleared to zero, whatever the operands are.
- R7: With REG_OUT=0, the output follows the operands with no clock edge in between, and reset has no effect on it.
- R8: At N=4, operands 4'b1011 and 4'b1101 give 8'b10001111 (143).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the checks |
| rst | input | 1 | Synchronous active-high reset; clears the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| p | output | 2N | Unsigned product |

## Verification
In the registered form, a product is due at the first rising edge after the operands are applied. The bench therefore changes the operands on a falling edge and reads the result on the next falling edge, half a period after the capturing edge. The unregistered 2-bit instance has no clock stage, so it is read one nanosecond after its operands change. The reset check raises reset with non-zero operands present and reads a zero output at the following falling edge. It then releases reset and expects the product again one edge later.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // smallest width handled by the crosswise base cell
  localparam int BASE_W = 2;

  function automatic int half(input int w);
    return w / 2;
  endfunction
endpackage

// File: rtl/vcm_base2x2.sv
module vcm_base2x2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic col1_carry;
  logic top_and;

  always_comb begin
    top_and    = a[1] & b[1];
    col1_carry = (a[1] & b[0]) & (a[0] & b[1]);
    p[0]       = a[0] & b[0];
    p[1]       = (a[1] & b[0]) ^ (a[0] & b[1]);
    p[2]       = top_and ^ col1_carry;
    p[3]       = top_and & col1_carry;
  end
endmodule

// File: rtl/vcm_rca.sv
module vcm_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign co = c[W];
endmodule

// File: rtl/vcm_node.sv
module vcm_node #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = vcm_pkg::half(W);

  if (W == vcm_pkg::BASE_W) begin : g_base
    vcm_base2x2 u_cell (
      .a (a),
      .b (b),
      .p (p)
    );

    // R3
    base_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
      p[3] |-> (p == 4'd9));
  end else begin : g_split
    logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
    logic [W-1:0] mid_s, low_s, top_s;
    logic [W-1:0] low_addend, top_addend;
    logic         mid_co, low_co, top_co;
    logic         carry_h;

    vcm_node #(.W(H)) u_ll (.clk(clk), .rst(rst), .a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));
    vcm_node #(.W(H)) u_lh (.clk(clk), .rst(rst), .a(a[H-1:0]), .b(b[W-1:H]), .p(pp_lh));
    vcm_node #(.W(H)) u_hl (.clk(clk), .rst(rst), .a(a[W-1:H]), .b(b[H-1:0]), .p(pp_hl));
    vcm_node #(.W(H)) u_hh (.clk(clk), .rst(rst), .a(a[W-1:H]), .b(b[W-1:H]), .p(pp_hh));

    // cross products summed first
    vcm_rca #(.W(W)) u_mid (.x(pp_hl), .y(pp_lh), .s(mid_s), .co(mid_co));

    // cross sum aligned at H against the upper half of ll
    assign low_addend = {{H{1'b0}}, pp_ll[W-1:H]};
    vcm_rca #(.W(W)) u_low (.x(mid_s), .y(low_addend), .s(low_s), .co(low_co));

    // both carries weigh 2^(W+H); at most one can be set
    assign carry_h    = mid_co ^ low_co;
    assign top_addend = {{(H-1){1'b0}}, carry_h, low_s[W-1:H]};
    vcm_rca #(.W(W)) u_top (.x(pp_hh), .y(top_addend), .s(top_s), .co(top_co));

    assign p = {top_s, low_s[H-1:0], pp_ll[H-1:0]};

    // R5
    mid_carry_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mid_co && low_co));

    // R4
    top_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      !top_co);
  end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int PW = 2 * N;

  logic [PW-1:0] prod;

  vcm_node #(.W(N)) u_root (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .p   (prod)
  );

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] p_q;

    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else     p_q <= prod;
    end

    assign p = p_q;

    // R1 R6
    reg_product_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (p == (PW'($past(a)) * PW'($past(b)))));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (p == '0));
  end else begin : g_comb
    assign p = prod;

    // R1 R7
    comb_product_chk: assert property (@(posedge clk) disable iff (rst)
      p == (PW'(a) * PW'(b)));
  end
endmodule

// File: tb/vcm_mult_tb.sv
module vcm_mult_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;
  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  p2;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  vcm_mult #(.N(8), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .p(p8));
  vcm_mult #(.N(4), .REG_OUT(1'b1)) u_dut_n4 (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .p(p4));
  vcm_mult #(.N(2), .REG_OUT(1'b0)) u_dut_n2 (
    .clk(clk), .rst(rst), .a(a2), .b(b2), .p(p2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // registered 8-bit pair: drive on falling edge, read at next falling edge
  task automatic run8(input string req, input logic [7:0] x, input logic [7:0] y);
    logic [15:0] e;
    e = 16'(x) * 16'(y);
    @(negedge clk);
    a8 = x; b8 = y;
    @(negedge clk);
    check(req, 32'(p8), 32'(e));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R6 reset p8", 32'(p8), 32'h0);
    check("R6 reset p4", 32'(p4), 32'h0);
    a8 = 8'hC3; b8 = 8'h5A; a4 = 4'hF; b4 = 4'h7;
    @(negedge clk);
    check("R6 reset ignores operands p8", 32'(p8), 32'h0);
    check("R6 reset ignores operands p4", 32'(p4), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 product after release", 32'(p8), 32'(16'hC3 * 16'h5A));
    check("R6 product after release n4", 32'(p4), 32'(105));
  endtask

  task automatic t_exhaustive4();
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        a4 = 4'(i); b4 = 4'(j);
        @(negedge clk);
        check("R1 exhaustive 4x4", 32'(p4), 32'(i * j));
      end
    end
  endtask

  task automatic t_worked4();
    @(negedge clk);
    a4 = 4'b1011; b4 = 4'b1101;
    @(negedge clk);
    check("R8 1011x1101", 32'(p4), 32'b10001111);
  endtask

  task automatic t_base2();
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [1:0] x, y;
        x = 2'(i); y = 2'(j);
        a2 = x; b2 = y;
        #1;
        check("R7 R3 comb 2x2", 32'(p2), 32'(i * j));
        check("R3 bit0", 32'(p2[0]), 32'(x[0] & y[0]));
        check("R3 bit1", 32'(p2[1]), 32'((x[1] & y[0]) ^ (x[0] & y[1])));
        check("R3 bit3 only for 9", 32'(p2[3]), 32'(i == 3 && j == 3));
      end
    end
  endtask

  task automatic t_reset_comb();
    // R7: reset does not touch the unregistered output
    a2 = 2'd3; b2 = 2'd2;
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R7 comb ignores reset", 32'(p2), 32'd6);
    @(negedge clk);
    check("R7 comb ignores reset later", 32'(p2), 32'd6);
    rst = 1'b0;
  endtask

  task automatic t_corners8();
    run8("R5 all ones", 8'hFF, 8'hFF);
    check("R5 all ones value", 32'(p8), 32'h0000FE01);
    run8("R1 zero x ones", 8'h00, 8'hFF);
    run8("R1 ones x zero", 8'hFF, 8'h00);
    run8("R1 one x ones", 8'h01, 8'hFF);
    run8("R1 ones x one", 8'hFF, 8'h01);
    run8("R1 one x one", 8'h01, 8'h01);
    run8("R5 ff x fe", 8'hFF, 8'hFE);
  endtask

  task automatic t_cross8();
    // R2: isolate each quadrant term
    run8("R2 hi x lo", 8'hF0, 8'h0F);
    check("R2 hi x lo shift 4", 32'(p8), 32'(16'h0E1 << 4));
    run8("R2 lo x hi", 8'h0F, 8'hF0);
    run8("R2 hi x hi", 8'hF0, 8'hF0);
    check("R2 hi x hi shift 8", 32'(p8), 32'(16'hE1 << 8));
    run8("R2 lo x lo", 8'h0F, 8'h0F);
    check("R2 lo x lo unshifted", 32'(p8), 32'h000000E1);
    run8("R2 R5 cross carry", 8'hFF, 8'h0F);
  endtask

  task automatic t_random8();
    for (int k = 0; k < 1500; k++) begin
      run8("R1 random 8x8", 8'($urandom), 8'($urandom));
    end
  endtask

  task automatic t_back_to_back();
    // R6: consecutive edges each deliver their own product
    @(negedge clk);
    a8 = 8'd200; b8 = 8'd3;
    @(negedge clk);
    check("R6 first of pair", 32'(p8), 32'd600);
    a8 = 8'd17; b8 = 8'd19;
    @(negedge clk);
    check("R6 second of pair", 32'(p8), 32'd323);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_exhaustive4();
    t_worked4();
    t_base2();
    t_reset_comb();
    @(negedge clk);
    @(negedge clk);
    t_corners8();
    t_cross8();
    t_back_to_back();
    t_random8();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule